// File: doc/BRIEF.md
# Transmit Abort Source Capture

This block sits beside the master state machine of a two-wire serial bus controller and records why a transfer was abandoned. It takes single-cycle cause pulses from the protocol engine, such as a missing acknowledge or lost arbitration. It also watches each command word as it is issued and compares it with the static configuration. Some combinations can never succeed on the bus, so the block raises an abort for them before any bus activity starts.

When any cause appears while no abort is held, the block stores it as a single bit in a 16-bit source register. It sets the abort flag and, in the following cycle, pulses a flush strobe that empties both the transmit and receive FIFOs. While the strobe is high, push requests into either FIFO are blocked. Software reads the source register at one address. Reading the clear address releases the register so that the next cause can be captured.

Top module: `abrt_capture`

## Requirements
- R1: After reset the source register reads 0, and the abort flag and flush strobe are low.
- R2: A pulse on bit k of `cause_i` while no abort is held sets exactly bit k of the source register and the abort flag on the next clock edge.
- R3: A command issued (`cmd_valid_i` high) while `master_en_i` is low raises source bit 11.
- R4: With `restart_en_i` low, a command flagged as a start byte raises source bit 9, and a command flagged as high-speed raises source bit 8.
- R5: A command with bit 8 of `cmd_word_i` set (read), issued with `addr10_i` high and `restart_en_i` low, raises source bit 10. The same command with restart enabled, or as a write (bit 8 clear), raises nothing.
- R6: When several causes arrive in the same cycle, only the lowest-numbered one is recorded.
- R7: Once an abort is held, later causes leave the source register unchanged and raise no flush, until the register is cleared.
- R8: A read strobe at address 0x54 clears the source register and the abort flag on the next edge. A read at 0x54 returns the abort flag in bit 0 and zero in every other bit.
- R9: A read at address 0x80 returns the source register. A read at any other address returns 0.
- R10: The flush strobe is high for exactly the one cycle after a capture, and `tx_push_o` and `rx_push_o` are held low in that cycle.
- R11: If a clear read and a new cause occur in the same cycle, the new cause is captured and flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cause_i | input | 16 | Abort cause pulses from the protocol engine |
| cmd_valid_i | input | 1 | A command word is issued this cycle |
| cmd_word_i | input | 9 | Command word; bit 8 = read, bits 7:0 = data |
| cmd_sbyte_i | input | 1 | Command is a start-byte transfer |
| cmd_hs_i | input | 1 | Command uses high-speed mode |
| restart_en_i | input | 1 | Repeated-start generation enabled |
| addr10_i | input | 1 | 10-bit addressing enabled |
| master_en_i | input | 1 | Master function enabled |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 16 | Register read data |
| tx_push_i | input | 1 | Transmit FIFO push request |
| rx_push_i | input | 1 | Receive FIFO push request |
| tx_push_o | output | 1 | Gated transmit FIFO push |
| rx_push_o | output | 1 | Gated receive FIFO push |
| abort_src_o | output | 16 | Captured abort source |
| abort_o | output | 1 | Abort held |
| flush_o | output | 1 | FIFO flush strobe |

## Verification
The assertions assume that cause pulses and command words arrive synchronously to the clock and only after reset has been released. They also assume that a clear is expressed only as a read strobe with address 0x54. The bench meets these assumptions by driving every input on the falling edge. Its random stimulus keeps cause pulses sparse, so that the held-abort state persists long enough for later causes to hit it. It issues clear reads at random, which sometimes coincide with new causes. Configuration bits are re-drawn at random, which often produces the restart-disabled and master-off conflicts.

// File: rtl/abrt_pkg.sv
package abrt_pkg;
  localparam int SRC_W      = 16;
  localparam int ADDR_W     = 8;
  localparam int CMD_W      = 9;
  localparam int CMD_RD_BIT = 8;
  localparam int BIT_HS_NORST  = 8;
  localparam int BIT_SB_NORST  = 9;
  localparam int BIT_RD10_NORST = 10;
  localparam int BIT_MST_OFF   = 11;
  localparam logic [ADDR_W-1:0] CLR_ADDR = 8'h54;
  localparam logic [ADDR_W-1:0] SRC_ADDR = 8'h80;
endpackage

// File: rtl/abrt_cfg_check.sv
module abrt_cfg_check
  import abrt_pkg::*;
#(
  parameter int W = SRC_W
) (
  input  logic         cmd_valid_i,
  input  logic         cmd_rd_i,
  input  logic         cmd_sbyte_i,
  input  logic         cmd_hs_i,
  input  logic         restart_en_i,
  input  logic         addr10_i,
  input  logic         master_en_i,
  output logic [W-1:0] conflict_o
);
  always_comb begin
    conflict_o = '0;
    if (cmd_valid_i) begin
      conflict_o[BIT_MST_OFF]    = !master_en_i;
      conflict_o[BIT_SB_NORST]   = cmd_sbyte_i && !restart_en_i;
      conflict_o[BIT_HS_NORST]   = cmd_hs_i && !restart_en_i;
      conflict_o[BIT_RD10_NORST] = cmd_rd_i && addr10_i && !restart_en_i;
    end
  end
endmodule

// File: rtl/abrt_prio_pick.sv
module abrt_prio_pick #(
  parameter int W = 16
) (
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] pick_o,
  output logic         any_o
);
  logic [W:0] seen;
  assign seen[0] = 1'b0;
  // lowest index wins
  for (genvar i = 0; i < W; i++) begin : g_pick
    assign pick_o[i]  = vec_i[i] && !seen[i];
    assign seen[i+1]  = seen[i] || vec_i[i];
  end
  assign any_o = seen[W];
endmodule

// File: rtl/abrt_src_latch.sv
module abrt_src_latch #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pick_i,
  input  logic         any_i,
  input  logic         clr_i,
  output logic [W-1:0] src_o,
  output logic         abort_o,
  output logic         flush_o
);
  logic [W-1:0] src_q;
  logic         abort_q, flush_q;
  logic         capture;

  assign capture = any_i && (!abort_q || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      abort_q <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= capture;
      if (capture) begin
        src_q   <= pick_i;
        abort_q <= 1'b1;
      end else if (clr_i) begin
        src_q   <= '0;
        abort_q <= 1'b0;
      end
    end
  end

  assign src_o   = src_q;
  assign abort_o = abort_q;
  assign flush_o = flush_q;

  AST_SRC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_q)); // R6
  AST_HOLD_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q && !clr_i |=> $stable(src_q) && !flush_q); // R7
  AST_FLUSH_AFTER_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_i && (!abort_q || clr_i) |=> flush_q && abort_q); // R10
  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !any_i |=> !abort_q && (src_q == '0)); // R8
  AST_FLUSH_HAS_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |-> (src_q != '0) && abort_q); // R10
endmodule

// File: rtl/abrt_capture.sv
module abrt_capture
  import abrt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SRC_W-1:0]  cause_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  input  logic              cmd_sbyte_i,
  input  logic              cmd_hs_i,
  input  logic              restart_en_i,
  input  logic              addr10_i,
  input  logic              master_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [SRC_W-1:0]  rd_data_o,
  input  logic              tx_push_i,
  input  logic              rx_push_i,
  output logic              tx_push_o,
  output logic              rx_push_o,
  output logic [SRC_W-1:0]  abort_src_o,
  output logic              abort_o,
  output logic              flush_o
);
  logic [SRC_W-1:0] conflict, all_causes, pick;
  logic             any_cause, clr;

  abrt_cfg_check #(.W(SRC_W)) u_cfg (
    .cmd_valid_i (cmd_valid_i),
    .cmd_rd_i    (cmd_word_i[CMD_RD_BIT]),
    .cmd_sbyte_i (cmd_sbyte_i),
    .cmd_hs_i    (cmd_hs_i),
    .restart_en_i(restart_en_i),
    .addr10_i    (addr10_i),
    .master_en_i (master_en_i),
    .conflict_o  (conflict)
  );

  assign all_causes = conflict | cause_i;

  abrt_prio_pick #(.W(SRC_W)) u_pick (
    .vec_i (all_causes),
    .pick_o(pick),
    .any_o (any_cause)
  );

  assign clr = rd_en_i && (rd_addr_i == CLR_ADDR);

  abrt_src_latch #(.W(SRC_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pick_i (pick),
    .any_i  (any_cause),
    .clr_i  (clr),
    .src_o  (abort_src_o),
    .abort_o(abort_o),
    .flush_o(flush_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == SRC_ADDR)      rd_data_o = abort_src_o;
    else if (rd_addr_i == CLR_ADDR) rd_data_o[0] = abort_o;
  end

  assign tx_push_o = tx_push_i && !flush_o;
  assign rx_push_o = rx_push_i && !flush_o;

  AST_MASTER_OFF_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !master_en_i && !abort_o |=> abort_o && flush_o); // R3
endmodule

// File: tb/abrt_capture_test.sv
`timescale 1ns/1ps
module abrt_capture_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cause = '0;
  logic cv = 0, sb = 0, hs = 0, rs = 1, a10 = 0, men = 1, rde = 0, tpi = 0, rpi = 0;
  logic [8:0] word = '0;
  logic [7:0] ra = '0;
  logic [15:0] rdata, src;
  logic tpo, rpo, abt, fl;
  int n_chk = 0, n_fail = 0;
  logic [15:0] e_src = '0;
  logic e_flush = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  abrt_capture uut (
    .clk_i(clk), .rst_ni(rst_n), .cause_i(cause), .cmd_valid_i(cv), .cmd_word_i(word),
    .cmd_sbyte_i(sb), .cmd_hs_i(hs), .restart_en_i(rs), .addr10_i(a10), .master_en_i(men),
    .rd_en_i(rde), .rd_addr_i(ra), .rd_data_o(rdata), .tx_push_i(tpi), .rx_push_i(rpi),
    .tx_push_o(tpo), .rx_push_o(rpo), .abort_src_o(src), .abort_o(abt), .flush_o(fl)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] all_causes();
    logic [15:0] v = cause;
    if (cv) begin
      if (!men) v[11] = 1'b1;
      if (sb && !rs) v[9] = 1'b1;
      if (hs && !rs) v[8] = 1'b1;
      if (word[8] && a10 && !rs) v[10] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [15:0] lowest(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 16'h1 << i;
    return 16'h0;
  endfunction

  // called at negedge after inputs are set; advances the model and checks
  task automatic step(input string tag);
    logic [15:0] v = all_causes();
    logic clr = rde && (ra == 8'h54);
    logic cap = (v != 0) && ((e_src == 0) || clr);
    logic [15:0] exp_rd;
    e_flush = cap;
    if (cap) e_src = lowest(v);
    else if (clr) e_src = '0;
    @(negedge clk);
    exp_rd = (ra == 8'h80) ? e_src : (ra == 8'h54) ? {15'b0, e_src != 0} : 16'h0;
    check(src === e_src, tag, src, e_src);
    check(abt === (e_src != 0), {tag, "/R8 abort flag"}, {15'b0, abt}, {15'b0, e_src != 0});
    check(fl === e_flush, {tag, "/R10 flush"}, {15'b0, fl}, {15'b0, e_flush});
    check(tpo === (tpi && !e_flush) && rpo === (rpi && !e_flush), {tag, "/R10 push gate"},
          {14'b0, tpo, rpo}, {14'b0, tpi && !e_flush, rpi && !e_flush});
    check(rdata === exp_rd, {tag, "/R9 read data"}, rdata, exp_rd);
  endtask

  task automatic idle();
    cause = '0; cv = 0; sb = 0; hs = 0; word = '0; rde = 0;
  endtask

  task automatic do_clear();
    idle(); rde = 1; ra = 8'h54; step("R8 clear"); rde = 0;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check(src === 0 && abt === 0 && fl === 0, "R1 reset", {src[13:0], abt, fl}, 16'h0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    ra = 8'h80; idle(); step("R1 idle");
    // R2: engine pulse on bit 3
    cause = 16'h0008; step("R2 data noack");
    // R7: later cause ignored
    cause = 16'h1000; step("R7 later cause");
    idle(); step("R7 hold");
    do_clear();
    // R3 master off
    men = 0; cv = 1; step("R3 master off"); men = 1; do_clear();
    // R4 start byte / high speed with restart disabled
    rs = 0; cv = 1; sb = 1; step("R4 start byte"); do_clear();
    rs = 0; cv = 1; hs = 1; step("R4 high speed"); do_clear();
    // R5 10-bit read
    rs = 0; a10 = 1; cv = 1; word = 9'h1A5; step("R5 10-bit read"); do_clear();
    rs = 1; cv = 1; word = 9'h1A5; step("R5 restart on no abort");
    rs = 0; cv = 1; word = 9'h0A5; step("R5 write no abort");
    idle(); rs = 1; a10 = 0;
    // R6 simultaneous: bit 12 vs bit 4 vs master off
    men = 0; cv = 1; cause = 16'h1010; step("R6 lowest wins"); men = 1;
    // R11 clear together with new cause
    idle(); rde = 1; ra = 8'h54; cause = 16'h4000; step("R11 clear plus cause");
    idle(); ra = 8'h54; step("R8 read flag");
    ra = 8'h33; step("R9 other address");
    ra = 8'h80; do_clear();
    // R10 push blocked during flush
    tpi = 1; rpi = 1; cause = 16'h0001; step("R10 capture");
    idle(); step("R10 flush cycle"); tpi = 0; rpi = 0;
    do_clear();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      idle();
      if ($urandom_range(0, 9) == 0) cause = 16'h1 << $urandom_range(0, 15);
      if ($urandom_range(0, 7) == 0) begin
        cv = 1; word = 9'($urandom); sb = $urandom_range(0, 3) == 0; hs = $urandom_range(0, 3) == 0;
      end
      if ($urandom_range(0, 15) == 0) begin
        rs = $urandom_range(0, 1); a10 = $urandom_range(0, 1); men = $urandom_range(0, 4) != 0;
      end
      rde = $urandom_range(0, 5) == 0;
      case ($urandom_range(0, 2))
        0: ra = 8'h54;
        1: ra = 8'h80;
        default: ra = 8'($urandom);
      endcase
      tpi = $urandom_range(0, 1); rpi = $urandom_range(0, 1);
      step("R2 random");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule